// File: doc/BRIEF.md
# HDLC Frame Address Screen

This block sits behind the flag-detection and bit de-stuffing logic of an HDLC receiver. It decides, frame by frame, whether the frame's address field belongs to this station. Its input is a clean byte stream with three strobes: frame start, byte valid and frame end. At each frame start it takes a snapshot of a 16-bit compare mask, four 16-bit station addresses and the address-width mode. It then compares the first one or two bytes of the frame against all four addresses in parallel, using the shared mask.

The address field is consumed by the block. Its outcome is reported once per frame as a decision pulse with an accept flag and a per-register hit vector. For an accepted frame, every byte after the address field is forwarded one cycle later, and the frame end is forwarded as an end pulse. A rejected frame produces nothing more until the next frame start.

A typical set-up loads one register with the station's own address and another with all ones, so that broadcast frames are also taken. The unused registers hold copies of the station address. Setting the mask to 0x00FF, or selecting one-byte mode, reduces the check to a single address byte.

Top module: `hdlc_addr_screen`

## Requirements
- R1: After reset, dec_vld, pay_vld and pay_end are low. Bytes and frame ends arriving before any frame start produce no output.
- R2: A frame is accepted when ((word ^ addr_i) & mask) == 0 holds for at least one register i. Register i occupies cmp_addr[16*i+15:16*i]. dec_hit bit i is set exactly for the registers that match, and dec_accept is the OR of dec_hit.
- R3: In one-byte mode (wide_mode = 0 at frame start), the decision is made on the first byte. The word is {0x00, byte}, and the upper eight mask bits are treated as zero.
- R4: In two-byte mode (wide_mode = 1 at frame start), the first byte forms the low byte of the word and the second byte forms the high byte. For example, 0x68 then 0xAA matches 0xAA68. No decision is issued after the first byte.
- R5: dec_vld pulses for one cycle, in the cycle after the byte that completes the address field.
- R6: For an accepted frame, each later byte appears on pay_byte with pay_vld one cycle after its input. A frame end appears as a pay_end pulse one cycle later.
- R7: For a rejected frame, pay_vld and pay_end stay low until the next frame start.
- R8: A frame end that arrives before the address field is complete produces, one cycle later, dec_vld with dec_accept = 0 and dec_hit = 0, and no pay_end.
- R9: The mask, the address registers and the mode are sampled at frame start. Changes made during the frame do not alter that frame's decision.
- R10: A frame start during a frame abandons it and begins a new address field. Any byte_vld in a cycle with frame_start or frame_end high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Strobe: a new frame begins; the next byte is the first address byte |
| frame_end | input | 1 | Strobe: the current frame has ended |
| byte_vld | input | 1 | A de-stuffed byte is present on byte_in |
| byte_in | input | 8 | Received byte |
| wide_mode | input | 1 | 1 = two-byte address, 0 = one-byte address |
| cmp_mask | input | 16 | Compare mask; 1 = bit must match |
| cmp_addr | input | 64 | Four station addresses, register i at bits 16*i+15:16*i |
| dec_vld | output | 1 | Decision pulse for the current frame |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 4 | Matching registers |
| pay_vld | output | 1 | Forwarded payload byte valid |
| pay_byte | output | 8 | Forwarded payload byte |
| pay_end | output | 1 | End of an accepted frame |

## Verification
A wrong state register shows up quickly at the ports. A decision can go missing or be duplicated, or it can arrive one byte early or late, and this is visible in the cycle after the address byte. A stale snapshot or a swapped byte order shows as a wrong hit vector in that same decision pulse. A frame wrongly left in the pass state leaks payload bytes or an end pulse one cycle after the next input byte or frame end. The bench samples every one of these points in the exact cycle it expects them.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 2 * BYTE_W;
    localparam int N_ADDR_DEF = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_PASS,
        ST_DROP
    } scr_state_e;

    function automatic logic masked_eq(input logic [ADDR_W-1:0] word,
                                       input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] mask);
        return ((word ^ addr) & mask) == '0;
    endfunction

    function automatic logic [ADDR_W-1:0] eff_mask(input logic [ADDR_W-1:0] mask,
                                                   input logic wide);
        return wide ? mask : {{BYTE_W{1'b0}}, mask[BYTE_W-1:0]};
    endfunction
endpackage

// File: rtl/hdlc_cfg_snap.sv
module hdlc_cfg_snap
    import hdlc_addr_pkg::*;
#(
    parameter int N_ADDR = N_ADDR_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     in_wide,
    input  logic [ADDR_W-1:0]        in_mask,
    input  logic [N_ADDR*ADDR_W-1:0] in_addrs,
    output logic                     q_wide,
    output logic [ADDR_W-1:0]        q_mask,
    output logic [N_ADDR*ADDR_W-1:0] q_addrs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_wide  <= 1'b0;
            q_mask  <= '0;
            q_addrs <= '0;
        end else if (load) begin
            q_wide  <= in_wide;
            q_mask  <= in_mask;
            q_addrs <= in_addrs;
        end
    end
endmodule

// File: rtl/hdlc_masked_cmp.sv
module hdlc_masked_cmp
    import hdlc_addr_pkg::*;
#(
    parameter int N_ADDR = N_ADDR_DEF
) (
    input  logic [ADDR_W-1:0]        word,
    input  logic [ADDR_W-1:0]        mask,
    input  logic [N_ADDR*ADDR_W-1:0] addrs,
    output logic [N_ADDR-1:0]        hit
);
    for (genvar i = 0; i < N_ADDR; i++) begin : g_cmp
        assign hit[i] = masked_eq(word, addrs[i*ADDR_W +: ADDR_W], mask);
    end
endmodule

// File: rtl/hdlc_frame_fsm.sv
module hdlc_frame_fsm
    import hdlc_addr_pkg::*;
#(
    parameter int N_ADDR = N_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              wide,
    input  logic [N_ADDR-1:0] hit,
    output logic [ADDR_W-1:0] cmp_word,
    output logic              dec_vld,
    output logic              dec_accept,
    output logic [N_ADDR-1:0] dec_hit,
    output logic              pay_vld,
    output logic [BYTE_W-1:0] pay_byte,
    output logic              pay_end
);
    scr_state_e        state;
    logic [BYTE_W-1:0] lo_q;

    always_comb begin
        if (state == ST_ADR_HI) cmp_word = {byte_in, lo_q};
        else                    cmp_word = {{BYTE_W{1'b0}}, byte_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            lo_q       <= '0;
            dec_vld    <= 1'b0;
            dec_accept <= 1'b0;
            dec_hit    <= '0;
            pay_vld    <= 1'b0;
            pay_byte   <= '0;
            pay_end    <= 1'b0;
        end else begin
            dec_vld <= 1'b0;
            pay_vld <= 1'b0;
            pay_end <= 1'b0;
            if (frame_start) begin
                state <= ST_ADR_LO;
            end else if (frame_end) begin
                if (state == ST_ADR_LO || state == ST_ADR_HI) begin
                    dec_vld    <= 1'b1;
                    dec_accept <= 1'b0;
                    dec_hit    <= '0;
                end
                if (state == ST_PASS) pay_end <= 1'b1;
                state <= ST_IDLE;
            end else if (byte_vld) begin
                case (state)
                    ST_ADR_LO, ST_ADR_HI: begin
                        if (state == ST_ADR_LO && wide) begin
                            lo_q  <= byte_in;
                            state <= ST_ADR_HI;
                        end else begin
                            dec_vld    <= 1'b1;
                            dec_hit    <= hit;
                            dec_accept <= |hit;
                            state      <= (|hit) ? ST_PASS : ST_DROP;
                        end
                    end
                    ST_PASS: begin
                        pay_vld  <= 1'b1;
                        pay_byte <= byte_in;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/hdlc_addr_screen.sv
module hdlc_addr_screen
    import hdlc_addr_pkg::*;
#(
    parameter int N_ADDR = N_ADDR_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic                     frame_end,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        byte_in,
    input  logic                     wide_mode,
    input  logic [ADDR_W-1:0]        cmp_mask,
    input  logic [N_ADDR*ADDR_W-1:0] cmp_addr,
    output logic                     dec_vld,
    output logic                     dec_accept,
    output logic [N_ADDR-1:0]        dec_hit,
    output logic                     pay_vld,
    output logic [BYTE_W-1:0]        pay_byte,
    output logic                     pay_end
);
    logic                     snap_wide;
    logic [ADDR_W-1:0]        snap_mask;
    logic [N_ADDR*ADDR_W-1:0] snap_addrs;
    logic [ADDR_W-1:0]        word;
    logic [N_ADDR-1:0]        hit;

    hdlc_cfg_snap #(.N_ADDR(N_ADDR)) snap_i (
        .clk(clk), .rst(rst), .load(frame_start),
        .in_wide(wide_mode), .in_mask(cmp_mask), .in_addrs(cmp_addr),
        .q_wide(snap_wide), .q_mask(snap_mask), .q_addrs(snap_addrs)
    );

    hdlc_masked_cmp #(.N_ADDR(N_ADDR)) cmp_i (
        .word(word), .mask(eff_mask(snap_mask, snap_wide)),
        .addrs(snap_addrs), .hit(hit)
    );

    hdlc_frame_fsm #(.N_ADDR(N_ADDR)) fsm_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .byte_vld(byte_vld), .byte_in(byte_in), .wide(snap_wide), .hit(hit),
        .cmp_word(word), .dec_vld(dec_vld), .dec_accept(dec_accept),
        .dec_hit(dec_hit), .pay_vld(pay_vld), .pay_byte(pay_byte),
        .pay_end(pay_end)
    );
endmodule

// File: rtl/hdlc_addr_screen_chk.sv
module hdlc_addr_screen_chk
    import hdlc_addr_pkg::*;
#(
    parameter int N_ADDR = N_ADDR_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              frame_end,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_in,
    input logic              dec_vld,
    input logic              dec_accept,
    input logic [N_ADDR-1:0] dec_hit,
    input logic              pay_vld,
    input logic [BYTE_W-1:0] pay_byte,
    input logic              pay_end
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!dec_vld && !pay_vld && !pay_end)); // R1
    AST_ACCEPT_MATCHES_HIT: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> (dec_accept == (dec_hit != '0))); // R2
    AST_DEC_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> $past(byte_vld || frame_end)); // R5
    AST_DEC_NOT_WITH_PAY: assert property (@(posedge clk) disable iff (rst)
        !(dec_vld && (pay_vld || pay_end))); // R5
    AST_PAY_ECHOES_INPUT: assert property (@(posedge clk) disable iff (rst)
        pay_vld |-> ($past(byte_vld) && pay_byte == $past(byte_in))); // R6
    AST_END_ECHOES_INPUT: assert property (@(posedge clk) disable iff (rst)
        pay_end |-> $past(frame_end)); // R6
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && !dec_accept) |=> (!pay_vld && !pay_end)); // R7
    AST_SHORT_REJECT: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && $past(frame_end)) |-> (!dec_accept && dec_hit == '0)); // R8
    AST_STROBE_BLOCKS_BYTE: assert property (@(posedge clk) disable iff (rst)
        $past(frame_start) |-> (!dec_vld && !pay_vld)); // R10
endmodule

bind hdlc_addr_screen hdlc_addr_screen_chk #(.N_ADDR(N_ADDR)) chk_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
    .byte_vld(byte_vld), .byte_in(byte_in), .dec_vld(dec_vld),
    .dec_accept(dec_accept), .dec_hit(dec_hit), .pay_vld(pay_vld),
    .pay_byte(pay_byte), .pay_end(pay_end)
);

// File: tb/hdlc_addr_screen_tb_top.sv
module hdlc_addr_screen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        frame_end = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        wide_mode = 1'b1;
    logic [15:0] cmp_mask = 16'hFFFF;
    logic [63:0] cmp_addr;
    logic        dec_vld, dec_accept, pay_vld, pay_end;
    logic [3:0]  dec_hit;
    logic [7:0]  pay_byte;

    localparam logic [63:0] ADDRS_DEF = {16'h0055, 16'h1234, 16'hFFFF, 16'hAA68};

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hdlc_addr_screen dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_end(frame_end),
        .byte_vld(byte_vld), .byte_in(byte_in), .wide_mode(wide_mode),
        .cmp_mask(cmp_mask), .cmp_addr(cmp_addr), .dec_vld(dec_vld),
        .dec_accept(dec_accept), .dec_hit(dec_hit), .pay_vld(pay_vld),
        .pay_byte(pay_byte), .pay_end(pay_end)
    );

    typedef struct packed {
        logic        wide;
        logic [15:0] mask;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [3:0]  hit;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'hFFFF, 8'h68, 8'hAA, 4'b0001},
        '{1'b1, 16'hFFFF, 8'hFF, 8'hFF, 4'b0010},
        '{1'b1, 16'hFFFF, 8'h34, 8'h12, 4'b0100},
        '{1'b1, 16'hFFFF, 8'h11, 8'h22, 4'b0000},
        '{1'b0, 16'hFFFF, 8'h55, 8'h00, 4'b1000},
        '{1'b0, 16'hFFFF, 8'h68, 8'h00, 4'b0001},
        '{1'b0, 16'h00FF, 8'hFF, 8'h00, 4'b0010},
        '{1'b1, 16'h00FF, 8'h68, 8'h00, 4'b0001},
        '{1'b1, 16'h0000, 8'h01, 8'h02, 4'b1111},
        '{1'b0, 16'h000F, 8'h04, 8'h00, 4'b0100},
        '{1'b1, 16'hFF00, 8'h00, 8'hAA, 4'b0001},
        '{1'b0, 16'h00FF, 8'h00, 8'h00, 4'b0000}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic pulse_start();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic pulse_end();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic check_dec(input string req, input logic acc, input logic [3:0] hit);
        check(req, "dec_vld", 32'(dec_vld), 32'd1);
        check(req, "dec_accept", 32'(dec_accept), 32'(acc));
        check(req, "dec_hit", 32'(dec_hit), 32'(hit));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cmp_addr = ADDRS_DEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet after reset, nothing before the first frame start
        check("R1", "dec_vld", 32'(dec_vld), 32'd0);
        check("R1", "pay_vld", 32'(pay_vld), 32'd0);
        check("R1", "pay_end", 32'(pay_end), 32'd0);
        send_byte(8'h68);
        check("R1", "dec_vld no frame", 32'(dec_vld), 32'd0);
        check("R1", "pay_vld no frame", 32'(pay_vld), 32'd0);
        pulse_end();
        check("R1", "pay_end no frame", 32'(pay_end), 32'd0);
        check("R1", "dec_vld on end", 32'(dec_vld), 32'd0);

        // R2 R3 R4 R5 R6 R7: table of frames
        for (int i = 0; i < NV; i++) begin
            logic acc;
            acc       = |TBL[i].hit;
            wide_mode = TBL[i].wide;
            cmp_mask  = TBL[i].mask;
            pulse_start();
            send_byte(TBL[i].b0);
            if (TBL[i].wide) begin
                check("R4", "no dec after first byte", 32'(dec_vld), 32'd0);
                send_byte(TBL[i].b1);
                check_dec("R4", acc, TBL[i].hit);
            end else begin
                check_dec("R3", acc, TBL[i].hit);
            end
            for (int k = 0; k < 2; k++) begin
                send_byte(8'hC0 + 8'(i * 2 + k));
                check(acc ? "R6" : "R7", "pay_vld", 32'(pay_vld), 32'(acc));
                if (acc) check("R6", "pay_byte", 32'(pay_byte), 32'(8'hC0 + 8'(i * 2 + k)));
                check("R5", "dec_vld single pulse", 32'(dec_vld), 32'd0);
            end
            pulse_end();
            check(acc ? "R6" : "R7", "pay_end", 32'(pay_end), 32'(acc));
            @(negedge clk);
        end

        // R8: short frames
        wide_mode = 1'b1;
        cmp_mask  = 16'hFFFF;
        pulse_start();
        send_byte(8'h68);
        pulse_end();
        check_dec("R8", 1'b0, 4'b0000);
        check("R8", "pay_end two-byte short", 32'(pay_end), 32'd0);
        wide_mode = 1'b0;
        pulse_start();
        pulse_end();
        check_dec("R8", 1'b0, 4'b0000);
        check("R8", "pay_end empty", 32'(pay_end), 32'd0);

        // R9: configuration changed mid-frame has no effect
        wide_mode = 1'b1;
        cmp_mask  = 16'hFFFF;
        pulse_start();
        wide_mode = 1'b0;
        cmp_mask  = 16'h0000;
        cmp_addr  = 64'h0;
        send_byte(8'h68);
        check("R9", "mode kept: no dec yet", 32'(dec_vld), 32'd0);
        send_byte(8'hAA);
        check_dec("R9", 1'b1, 4'b0001);
        pulse_end();
        check("R9", "pay_end", 32'(pay_end), 32'd1);
        cmp_addr = ADDRS_DEF;

        // R10: restart mid-frame, and byte during frame start ignored
        wide_mode = 1'b1;
        cmp_mask  = 16'hFFFF;
        pulse_start();
        send_byte(8'h68);
        send_byte(8'hAA);
        check_dec("R10", 1'b1, 4'b0001);
        pulse_start();
        send_byte(8'h11);
        send_byte(8'h22);
        check_dec("R10", 1'b0, 4'b0000);
        send_byte(8'h5A);
        check("R10", "pay_vld after restart", 32'(pay_vld), 32'd0);
        pulse_end();
        check("R10", "pay_end after restart", 32'(pay_end), 32'd0);

        wide_mode   = 1'b0;
        cmp_mask    = 16'h00FF;
        frame_start = 1'b1;
        byte_vld    = 1'b1;
        byte_in     = 8'h11;
        @(negedge clk);
        frame_start = 1'b0;
        byte_vld    = 1'b0;
        check("R10", "no dec on start cycle", 32'(dec_vld), 32'd0);
        send_byte(8'h68);
        check_dec("R10", 1'b1, 4'b0001);
        pulse_end();
        check("R10", "pay_end", 32'(pay_end), 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule